// File: doc/BRIEF.md
# Byte-Lane Register Bank Bridge

This block is a Wishbone classic slave placed in front of a small bank of 8-bit registers. The registers sit at consecutive byte offsets. Each 32-bit bus access is split into four byte lanes. Lane i serves the register at byte offset A+i, where A is the low twelve address bits. The bank answers only when the upper address bits match its base address. Reads gather four byte registers into one word. Writes touch only the lanes whose select bit is set, and inside each byte only the writable bits.

A few example fields show the rules. The byte at offset 0 is a status register: its low four bits follow the power-good input pins live, and its upper bits read as zero. The byte at offset 3 has a writable low nibble and a fixed upper nibble. Every other byte below the bank size is fully writable.

One register word, the GPIO data word, is committed to its pads at the end of a serial transfer. Writes to it are acknowledged only after a configurable extra delay. A master keeps its request stable until the acknowledge arrives and receives exactly one acknowledge per request.

Top module: `wb_byte_reg_bridge`

## Requirements
- R1: During and right after reset `wb_ack_o` is low. The register bytes take their reset values: offset 1 = 0x5A, offset 3 = 0xA0, all other stored bytes = 0x00.
- R2: A request is decoded only when adr[31:13] equals BASE_ADDR[31:13]; adr[12] is ignored. A request that does not match is still acknowledged, returns 0x00000000 on a read, and changes no register.
- R3: A read at byte offset A = adr[11:0] returns byte lane i (bits 8i+7..8i) from the register at offset A+i, for i = 0..3, including when A is not a multiple of four.
- R4: Byte offsets at or above NUM_REGS have no register behind them: they read as zero and writes to them are dropped.
- R5: On a write, lane i updates the byte at offset A+i from wb_dat_i[8i+7:8i] only when wb_sel_i[i] is 1; lanes with a clear select bit keep their value.
- R6: Bits not marked writable keep their state on a write: at offset 3 only bits [3:0] are writable, and bits [7:4] keep reading 0xA.
- R7: The byte at offset 0 reads as {4'b0000, pwr_good_i}, follows the pins live, and is not changed by writes.
- R8: A read accepted at a rising edge (cyc and stb both high while idle) raises `wb_ack_o` for the following cycle, with `wb_dat_o` valid in that same cycle.
- R9: An ordinary write raises `wb_ack_o` in the second cycle after the accepting edge, and the new value is visible to the next read.
- R10: A write whose byte offset equals SLOW_OFS is acknowledged SLOW_EXTRA cycles later than an ordinary write.
- R11: Each accepted request yields exactly one `wb_ack_o` pulse, one cycle wide.
- R12: No acknowledge is produced unless cyc and stb are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wb_cyc_i | input | 1 | Bus cycle active |
| wb_stb_i | input | 1 | Request strobe |
| wb_we_i | input | 1 | 1 = write, 0 = read |
| wb_adr_i | input | 32 | Byte address |
| wb_dat_i | input | 32 | Write data, lane i in bits 8i+7..8i |
| wb_sel_i | input | 4 | Byte-lane select for writes |
| pwr_good_i | input | 4 | Live power-good status bits |
| wb_dat_o | output | 32 | Read data |
| wb_ack_o | output | 1 | Request acknowledge |

## Verification
The bench builds the bridge with a 16-byte bank at base 0x2600_0000, the slow word at offset 12, and SLOW_EXTRA set to 5. With these values the slow acknowledge is seven cycles after acceptance, which sets it clearly apart from the two-cycle ordinary write. They also let a word near the top of the bank straddle the end of the implemented registers. The bench also sets address bit 12 and address bit 13, to show that one is ignored by the decode and the other misses the bank.

// File: rtl/wbrb_pkg.sv
// Shared constants, field layout and bus-state type for the byte-lane
// register bridge. Assumes an 8-bit register per byte offset.
package wbrb_pkg;

    localparam int unsigned LANES    = 4;
    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned WORD_W   = LANES * BYTE_W;
    localparam int unsigned OFS_W    = 12;
    localparam int unsigned HIT_LSB  = 13;

    // Offsets of the example fields
    localparam int unsigned STATUS_OFS = 0;
    localparam int unsigned IDENT_OFS  = 1;
    localparam int unsigned TRIM_OFS   = 3;

    typedef enum logic [1:0] {
        BUS_IDLE = 2'd0,
        BUS_WAIT = 2'd1,
        BUS_ACK  = 2'd2
    } bus_state_e;

    // Writable-bit mask of the byte register at offset idx
    function automatic logic [BYTE_W-1:0] writable_bits(int unsigned idx);
        if (idx == STATUS_OFS)    return 8'h00;
        else if (idx == TRIM_OFS) return 8'h0F;
        else                      return 8'hFF;
    endfunction

    // Reset value of the byte register at offset idx
    function automatic logic [BYTE_W-1:0] reset_byte(int unsigned idx);
        if (idx == IDENT_OFS)     return 8'h5A;
        else if (idx == TRIM_OFS) return 8'hA0;
        else                      return 8'h00;
    endfunction

endpackage

// File: rtl/wbrb_decode.sv
// Address decode: base match on the upper bits, per-lane byte offsets,
// lane-in-range flags and detection of the slow (serially committed) word.
// Purely combinational; assumes the address is stable while a request waits.
module wbrb_decode
    import wbrb_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR = 32'h2600_0000,
    parameter int unsigned NUM_REGS  = 16,
    parameter int unsigned SLOW_OFS  = 12
) (
    input  logic [31:0]                 adr,
    output logic                        base_hit,
    output logic                        slow_hit,
    output logic [LANES-1:0][OFS_W-1:0] lane_ofs,
    output logic [LANES-1:0]            lane_live
);

    localparam logic [OFS_W-1:0] SLOW_KEY = OFS_W'(SLOW_OFS);

    // Compare the bank-select bits with the base address
    always_comb begin
        base_hit = (adr[31:HIT_LSB] == BASE_ADDR[31:HIT_LSB]);
        slow_hit = base_hit && (adr[OFS_W-1:0] == SLOW_KEY);
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [OFS_W:0] sum;
        // Offset of lane i and whether a register exists there
        always_comb begin
            sum          = {1'b0, adr[OFS_W-1:0]} + (OFS_W+1)'(i);
            lane_ofs[i]  = sum[OFS_W-1:0];
            lane_live[i] = (sum < (OFS_W+1)'(NUM_REGS));
        end
    end

endmodule

// File: rtl/wbrb_byte_file.sv
// Bank of byte registers with per-bit write protection. The status byte is
// not stored; it shows the live power-good pins. Assumes at most one lane
// addresses a given register in one write (lane offsets are distinct).
module wbrb_byte_file
    import wbrb_pkg::*;
#(
    parameter int unsigned NUM_REGS = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [LANES-1:0]            wr_en,
    input  logic [WORD_W-1:0]           wr_data,
    input  logic [LANES-1:0][OFS_W-1:0] lane_ofs,
    input  logic [LANES-1:0]            lane_live,
    input  logic [3:0]                  pwr_good,
    output logic [WORD_W-1:0]           rd_data
);

    localparam int unsigned IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic [BYTE_W-1:0] view [NUM_REGS];

    for (genvar j = 0; j < NUM_REGS; j++) begin : g_reg
        localparam logic [BYTE_W-1:0] MASK   = writable_bits(j);
        localparam logic [BYTE_W-1:0] RSTV   = reset_byte(j);
        localparam logic [OFS_W-1:0]  MY_OFS = OFS_W'(j);
        if (j == STATUS_OFS) begin : g_status
            // Status byte mirrors the pins
            always_comb view[j] = {4'b0000, pwr_good};
        end else begin : g_store
            logic [BYTE_W-1:0] q;
            // Masked byte update from the lane that targets this offset
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= RSTV;
                end else begin
                    for (int i = 0; i < LANES; i++) begin
                        if (wr_en[i] && lane_live[i] && lane_ofs[i] == MY_OFS)
                            q <= (q & ~MASK) | (wr_data[i*BYTE_W +: BYTE_W] & MASK);
                    end
                end
            end
            always_comb view[j] = q;
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_rd
        // Gather lane i, zero when no register is behind it
        always_comb begin
            if (lane_live[i])
                rd_data[i*BYTE_W +: BYTE_W] = view[lane_ofs[i][IDX_W-1:0]];
            else
                rd_data[i*BYTE_W +: BYTE_W] = '0;
        end
    end

endmodule

// File: rtl/wbrb_ctrl.sv
// Bus sequencer: accepts a request while idle, answers reads after one cycle,
// commits writes after a wait (longer for the slow word) and pulses ack once.
// Assumes the master holds its request stable until ack.
module wbrb_ctrl
    import wbrb_pkg::*;
#(
    parameter int unsigned SLOW_EXTRA = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc,
    input  logic              stb,
    input  logic              we,
    input  logic [LANES-1:0]  sel,
    input  logic              base_hit,
    input  logic              slow_hit,
    input  logic [WORD_W-1:0] rd_word,
    output logic [LANES-1:0]  wr_en,
    output logic [WORD_W-1:0] dat_o,
    output logic              ack
);

    localparam int unsigned CW = $clog2(SLOW_EXTRA + 2);

    bus_state_e    state_q;
    logic [CW-1:0] wait_q;
    logic          accept;
    logic          commit;

    // Request acceptance and write commit strobes
    always_comb begin
        accept = (state_q == BUS_IDLE) && cyc && stb;
        commit = (state_q == BUS_WAIT) && (wait_q == '0);
        wr_en  = (commit && base_hit) ? sel : '0;
    end

    // State, wait counter and acknowledge register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
            wait_q  <= '0;
            ack     <= 1'b0;
        end else begin
            ack <= 1'b0;
            case (state_q)
                BUS_IDLE: if (accept) begin
                    if (we) begin
                        state_q <= BUS_WAIT;
                        wait_q  <= slow_hit ? CW'(SLOW_EXTRA) : '0;
                    end else begin
                        state_q <= BUS_ACK;
                        ack     <= 1'b1;
                    end
                end
                BUS_WAIT: begin
                    if (commit) begin
                        state_q <= BUS_ACK;
                        ack     <= 1'b1;
                    end else begin
                        wait_q <= wait_q - 1'b1;
                    end
                end
                default: state_q <= BUS_IDLE;
            endcase
        end
    end

    // Read data captured with the acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)
            dat_o <= '0;
        else if (accept && !we)
            dat_o <= base_hit ? rd_word : '0;
    end

    p_read_ack_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !we) |=> ack);

    p_write_not_early_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && we) |=> !ack);

    p_slow_wait_no_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BUS_WAIT && wait_q != '0) |=> !ack);

    p_ack_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    p_no_req_no_ack_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BUS_IDLE && !(cyc && stb)) |=> !ack);

    p_miss_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !we && !base_hit) |=> (ack && dat_o == '0));

endmodule

// File: rtl/wb_byte_reg_bridge.sv
// Top of the byte-lane register bridge: Wishbone classic slave in front of a
// bank of 8-bit registers at consecutive byte offsets. Assumes classic
// single-beat cycles with inputs held stable until ack.
module wb_byte_reg_bridge
    import wbrb_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR  = 32'h2600_0000,
    parameter int unsigned NUM_REGS   = 16,
    parameter int unsigned SLOW_OFS   = 12,
    parameter int unsigned SLOW_EXTRA = 9
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wb_cyc_i,
    input  logic        wb_stb_i,
    input  logic        wb_we_i,
    input  logic [31:0] wb_adr_i,
    input  logic [31:0] wb_dat_i,
    input  logic [3:0]  wb_sel_i,
    input  logic [3:0]  pwr_good_i,
    output logic [31:0] wb_dat_o,
    output logic        wb_ack_o
);

    logic                        base_hit;
    logic                        slow_hit;
    logic [LANES-1:0][OFS_W-1:0] lane_ofs;
    logic [LANES-1:0]            lane_live;
    logic [LANES-1:0]            wr_en;
    logic [WORD_W-1:0]           rd_word;

    wbrb_decode #(
        .BASE_ADDR (BASE_ADDR),
        .NUM_REGS  (NUM_REGS),
        .SLOW_OFS  (SLOW_OFS)
    ) u_decode (
        .adr       (wb_adr_i),
        .base_hit  (base_hit),
        .slow_hit  (slow_hit),
        .lane_ofs  (lane_ofs),
        .lane_live (lane_live)
    );

    wbrb_byte_file #(
        .NUM_REGS (NUM_REGS)
    ) u_file (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wb_dat_i),
        .lane_ofs  (lane_ofs),
        .lane_live (lane_live),
        .pwr_good  (pwr_good_i),
        .rd_data   (rd_word)
    );

    wbrb_ctrl #(
        .SLOW_EXTRA (SLOW_EXTRA)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cyc      (wb_cyc_i),
        .stb      (wb_stb_i),
        .we       (wb_we_i),
        .sel      (wb_sel_i),
        .base_hit (base_hit),
        .slow_hit (slow_hit),
        .rd_word  (rd_word),
        .wr_en    (wr_en),
        .dat_o    (wb_dat_o),
        .ack      (wb_ack_o)
    );

    p_no_ack_in_reset_r1: assert property (@(posedge clk)
        !rst_n |=> !wb_ack_o);

endmodule

// File: tb/tb_wb_byte_reg_bridge.sv
// Directed bench for the byte-lane register bridge.
module tb_wb_byte_reg_bridge;

    localparam int unsigned SLOW_EXTRA = 5;
    localparam logic [31:0] BASE       = 32'h2600_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
    logic [31:0] adr = '0, dat_i = '0;
    logic [3:0]  sel = '0;
    logic [3:0]  pg = 4'h9;
    logic [31:0] dat_o;
    logic        ack;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    wb_byte_reg_bridge #(
        .BASE_ADDR (BASE),
        .NUM_REGS  (16),
        .SLOW_OFS  (12),
        .SLOW_EXTRA(SLOW_EXTRA)
    ) dut (
        .clk(clk), .rst_n(rst_n), .wb_cyc_i(cyc), .wb_stb_i(stb),
        .wb_we_i(we), .wb_adr_i(adr), .wb_dat_i(dat_i), .wb_sel_i(sel),
        .pwr_good_i(pg), .wb_dat_o(dat_o), .wb_ack_o(ack)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // One bus request; returns read data and ack latency in cycles
    task automatic bus(input logic w, input logic [31:0] a, input logic [31:0] d,
                       input logic [3:0] s, output logic [31:0] rd, output int lat);
        @(negedge clk);
        cyc = 1; stb = 1; we = w; adr = a; dat_i = d; sel = s;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!ack && lat < 40);
        rd = dat_o;
        if (!ack) begin
            n_chk++; n_bad++;
            $display("FAIL R11: actual no ack expected ack within 40 cycles");
        end
        cyc = 0; stb = 0; we = 0;
        @(negedge clk);
        check("R11 single ack pulse", 32'(ack), 32'd0);
    endtask

    task automatic t_reset();
        logic [31:0] rd; int lat;
        check("R1 ack low in reset", 32'(ack), 32'd0);
        bus(0, BASE + 0, 0, 4'h0, rd, lat);
        check("R1 reset bytes 0..3", rd, 32'hA0_00_5A_09);
        check("R8 read latency", lat, 1);
    endtask

    task automatic t_full_write();
        logic [31:0] rd; int lat;
        bus(1, BASE + 4, 32'hDEADBEEF, 4'hF, rd, lat);
        check("R9 write latency", lat, 2);
        bus(0, BASE + 4, 0, 4'h0, rd, lat);
        check("R9 R3 readback", rd, 32'hDEADBEEF);
    endtask

    task automatic t_sel_lanes();
        logic [31:0] rd; int lat;
        bus(1, BASE + 8, 32'h11223344, 4'b0101, rd, lat);
        bus(0, BASE + 8, 0, 4'h0, rd, lat);
        check("R5 partial select", rd, 32'h00220044);
    endtask

    task automatic t_unaligned();
        logic [31:0] rd; int lat;
        bus(0, BASE + 2, 0, 4'h0, rd, lat);
        check("R3 unaligned read", rd, 32'hBEEF_A000);
    endtask

    task automatic t_readonly();
        logic [31:0] rd; int lat;
        bus(1, BASE + 0, 32'hFFFFFFFF, 4'hF, rd, lat);
        bus(0, BASE + 0, 0, 4'h0, rd, lat);
        check("R6 R7 protected bits", rd, 32'hAF_FF_FF_09);
    endtask

    task automatic t_live_status();
        logic [31:0] rd; int lat;
        pg = 4'h6;
        bus(0, BASE + 0, 0, 4'h0, rd, lat);
        check("R7 live status", rd[7:0], 32'h06);
    endtask

    task automatic t_range();
        logic [31:0] rd; int lat;
        bus(1, BASE + 14, 32'hFFFFFFFF, 4'hF, rd, lat);
        bus(0, BASE + 14, 0, 4'h0, rd, lat);
        check("R4 top of bank", rd, 32'h0000FFFF);
        bus(0, BASE + 32'h100, 0, 4'h0, rd, lat);
        check("R4 unbacked offset", rd, 32'h0);
    endtask

    task automatic t_miss();
        logic [31:0] rd; int lat;
        bus(1, BASE + 32'h2004, 32'h0, 4'hF, rd, lat);
        check("R2 miss write acked", lat, 2);
        bus(0, BASE + 4, 0, 4'h0, rd, lat);
        check("R2 miss changed nothing", rd, 32'hDEADBEEF);
        bus(0, BASE + 32'h2004, 0, 4'h0, rd, lat);
        check("R2 miss reads zero", rd, 32'h0);
        bus(0, BASE + 32'h1004, 0, 4'h0, rd, lat);
        check("R2 bit 12 ignored", rd, 32'hDEADBEEF);
    endtask

    task automatic t_slow();
        logic [31:0] rd; int lat;
        bus(1, BASE + 12, 32'h0BADF00D, 4'hF, rd, lat);
        check("R10 slow write latency", lat, 2 + SLOW_EXTRA);
        bus(0, BASE + 12, 0, 4'h0, rd, lat);
        check("R10 slow readback", rd, 32'h0BADF00D);
    endtask

    task automatic t_no_req();
        int seen = 0;
        @(negedge clk); stb = 1; cyc = 0;
        for (int k = 0; k < 4; k++) begin @(negedge clk); seen += int'(ack); end
        stb = 0; cyc = 1;
        for (int k = 0; k < 4; k++) begin @(negedge clk); seen += int'(ack); end
        cyc = 0;
        check("R12 no ack without cyc and stb", seen, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 ack low in reset", 32'(ack), 32'd0);
        rst_n = 1;
        t_reset();
        t_full_write();
        t_sel_lanes();
        t_unaligned();
        t_readonly();
        t_live_status();
        t_range();
        t_miss();
        t_slow();
        t_no_req();
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule